// File: doc/BRIEF.md
# Reset Source Arbitration Controller

This block gathers the chip's reset and supply-supervision inputs and merges them into one system reset output and one low-voltage interrupt. The reset inputs are a power-on flag, a precise low-voltage monitor (with a digital part and an analog part), a low-power-mode low-voltage monitor, an active-low reset pin, a watchdog expiry and a software request. The interrupt inputs are three voltage-window flags: analog low, digital low and analog high. The comparators that produce these flags are outside the block. Each flag arrives as a digital level.

Whether a source counts depends on the power mode: active, sleep or hibernate. During sleep, it also depends on a buzz window, which the power sequencer opens for periodic supervision. The block holds the reset for a fixed number of clock cycles after the last active source goes away. For the power-on case, this is what meets the minimum pulse width. A status register keeps the code of the most recent reset or interrupt cause. In sleep, a voltage event first requests a wakeup. The interrupt is raised only once the wakeup has finished.

Top module: `rst_source_arbiter`

## Requirements
- R1: `sys_rst_o` is high while any of these holds: `por_i` is high, a qualified precise or low-power low-voltage flag is present, `pin_rst_n_i` is low, `wdt_expire_i` is high, or `sw_rst_req_i` is high. The pin, watchdog and software sources raise it without waiting for a clock edge.
- R2: Reset release is synchronous. After the last clock edge at which a reset cause was sampled active, `sys_rst_o` stays high for exactly `HOLD_CYCLES` more edges (default 13). After `por_i` falls, it stays high for `HOLD_CYCLES` edges.
- R3: `status_o` holds the code of the most recent cause and stays unchanged when no cause is present. The codes are: 1 power-on, 2 precise low-voltage, 3 low-power low-voltage, 4 pin, 5 watchdog, 6 software, 7 analog low, 8 digital low, 9 analog high.
- R4: `por_i` sets `status_o` to 1 at once and overwrites any earlier cause. No other source returns it to 1.
- R5: When several reset causes are present at once, the smallest code among them is recorded. Among voltage interrupts, analog low wins over digital low, and digital low wins over analog high.
- R6: `sleep_lv_i` causes a reset only when `pmode_i` is 1 (sleep) or 2 (hibernate). It is ignored when `pmode_i` is 0 (active).
- R7: In active mode, `prec_dig_lv_i` always causes a reset. `prec_ana_lv_i` causes a reset only while `ana_reg_en_i` is 1.
- R8: The precise low-voltage flags are ignored in hibernate, and in sleep while `buzz_i` is 0. They are honoured in sleep while `buzz_i` is 1.
- R9: The voltage interrupt flags are ignored until the power-on reset hold has ended. `lv_irq_o` stays low throughout that hold.
- R10: In active mode, a rising edge of a voltage flag gives a one-cycle pulse on `lv_irq_o` at the next clock edge. At the same edge it writes that flag's code into `status_o`.
- R11: In sleep with `buzz_i` high, a rising voltage flag sets `wake_req_o` at the next edge, and `lv_irq_o` does not pulse. `wake_req_o` holds until an edge with `wake_done_i` high. At that edge it clears and `lv_irq_o` pulses for one cycle. Voltage flags are ignored in sleep without buzz and in hibernate.
- R12: The pin is passed through two flops before the status register sees it. `status_o` shows code 4 only after the third clock edge following the pin's fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| por_i | input | 1 | Power-on flag, active high; also resets the controller asynchronously |
| prec_dig_lv_i | input | 1 | Precise monitor, digital regulator below threshold |
| prec_ana_lv_i | input | 1 | Precise monitor, analog regulator below threshold |
| ana_reg_en_i | input | 1 | Analog regulator enabled |
| sleep_lv_i | input | 1 | Low-power low-voltage monitor tripped |
| pin_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_expire_i | input | 1 | Watchdog expired |
| sw_rst_req_i | input | 1 | Software reset request |
| ana_low_i | input | 1 | Analog supply below programmed level |
| dig_low_i | input | 1 | Digital supply below programmed level |
| ana_high_i | input | 1 | Analog supply above fixed level |
| pmode_i | input | 2 | Power mode: 0 active, 1 sleep, 2 hibernate |
| buzz_i | input | 1 | Sleep buzz window open |
| wake_done_i | input | 1 | Wakeup sequence finished |
| sys_rst_o | output | 1 | System reset, active high |
| wake_req_o | output | 1 | Wakeup request for a pending voltage event |
| lv_irq_o | output | 1 | Voltage interrupt pulse |
| status_o | output | 4 | Code of the most recent cause |

## Verification
- A wrong hold counter shows on `sys_rst_o` at release. The edge at which reset drops moves off `HOLD_CYCLES` after the last active cause, which is visible within one hold period.
- A wrong qualification or priority decision shows on `status_o` within three edges of the stimulus, since the synchronized pin path is the slowest.
- A stuck monitor-enable bit or pending-wake bit shows as a missing, early or repeated `lv_irq_o` pulse. It can also show as `wake_req_o` not clearing at the edge where `wake_done_i` is sampled.

// File: rtl/rsa_pkg.sv
package rsa_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE    = 2'd0,
        PM_SLEEP     = 2'd1,
        PM_HIBERNATE = 2'd2
    } pmode_e;

    typedef enum logic [3:0] {
        CS_NONE     = 4'd0,
        CS_POWERON  = 4'd1,
        CS_PRECISE  = 4'd2,
        CS_SLEEPLV  = 4'd3,
        CS_PIN      = 4'd4,
        CS_WATCHDOG = 4'd5,
        CS_SOFTWARE = 4'd6,
        CS_ALOW     = 4'd7,
        CS_DLOW     = 4'd8,
        CS_AHIGH    = 4'd9
    } cause_e;

    // controller state registered by the top module
    typedef struct packed {
        logic [3:0] status;
        logic       mon_en;
        logic       vprev;
        logic       wake_pend;
        logic       irq;
    } ctl_t;

endpackage

// File: rtl/rsa_sync2.sv
module rsa_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic d_i,
    output logic q_o
);
    logic [1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[0], d_i};
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) ff_q <= {2{RST_VAL}};
        else        ff_q <= ff_d;
    end

    assign q_o = ff_q[1];
endmodule

// File: rtl/rsa_prio.sv
// Fixed-priority pick: the lowest set index wins.
module rsa_prio #(
    parameter int N = 4,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = W'(i);
        end
    end
endmodule

// File: rtl/rsa_stretch.sv
// Holds busy_o for HOLD cycles after the last cycle req_i was sampled high.
module rsa_stretch #(
    parameter int HOLD = 13
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic req_i,
    output logic busy_o
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (req_i)            cnt_d = CW'(HOLD);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else                  cnt_d = cnt_q;
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) cnt_q <= CW'(HOLD);
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/rst_source_arbiter.sv
module rst_source_arbiter
    import rsa_pkg::*;
#(
    parameter int HOLD_CYCLES = 13
) (
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       prec_dig_lv_i,
    input  logic       prec_ana_lv_i,
    input  logic       ana_reg_en_i,
    input  logic       sleep_lv_i,
    input  logic       pin_rst_n_i,
    input  logic       wdt_expire_i,
    input  logic       sw_rst_req_i,
    input  logic       ana_low_i,
    input  logic       dig_low_i,
    input  logic       ana_high_i,
    input  logic [1:0] pmode_i,
    input  logic       buzz_i,
    input  logic       wake_done_i,
    output logic       sys_rst_o,
    output logic       wake_req_o,
    output logic       lv_irq_o,
    output logic [3:0] status_o
);
    localparam int NRST  = 5;
    localparam int NVOLT = 3;
    localparam int RW    = $clog2(NRST);
    localparam int VW    = $clog2(NVOLT);

    localparam ctl_t CTL_RST = '{status: CS_POWERON, mon_en: 1'b0,
                                 vprev: 1'b0, wake_pend: 1'b0, irq: 1'b0};

    ctl_t ctl_d, ctl_q;

    logic             pin_sync_n;
    logic             is_active, is_sleep, window;
    logic             prec_hit, slv_hit;
    logic [NRST-1:0]  rst_req;
    logic [NVOLT-1:0] volt_req;
    logic             rst_any, volt_any, hold_busy, rst_busy;
    logic [RW-1:0]    rst_idx;
    logic [VW-1:0]    volt_idx;

    rsa_sync2 #(.RST_VAL(1'b1)) u_pin_sync (
        .clk_i  (clk_i),
        .arst_i (por_i),
        .d_i    (pin_rst_n_i),
        .q_o    (pin_sync_n)
    );

    // source qualification by power mode and buzz window
    always_comb begin
        is_active = (pmode_e'(pmode_i) == PM_ACTIVE);
        is_sleep  = (pmode_e'(pmode_i) == PM_SLEEP);
        window    = is_active || (is_sleep && buzz_i);
        prec_hit  = (prec_dig_lv_i || (prec_ana_lv_i && ana_reg_en_i)) && window;
        slv_hit   = sleep_lv_i && !is_active;
        // index order is the recording priority (code = index + 2)
        rst_req   = {sw_rst_req_i, wdt_expire_i, !pin_sync_n, slv_hit, prec_hit};
        volt_req  = {ana_high_i, dig_low_i, ana_low_i}
                    & {NVOLT{ctl_q.mon_en && window}};
    end

    rsa_prio #(.N(NRST), .W(RW)) u_rst_prio (
        .req_i (rst_req),
        .any_o (rst_any),
        .idx_o (rst_idx)
    );

    rsa_prio #(.N(NVOLT), .W(VW)) u_volt_prio (
        .req_i (volt_req),
        .any_o (volt_any),
        .idx_o (volt_idx)
    );

    rsa_stretch #(.HOLD(HOLD_CYCLES)) u_stretch (
        .clk_i  (clk_i),
        .arst_i (por_i),
        .req_i  (rst_any),
        .busy_o (hold_busy)
    );

    assign rst_busy = rst_any || hold_busy;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.mon_en = ctl_q.mon_en || !rst_busy;
        if (rst_any) begin
            ctl_d.status = 4'(CS_PRECISE) + {{(4 - RW){1'b0}}, rst_idx};
        end
        if (rst_busy) begin
            ctl_d.vprev     = 1'b0;
            ctl_d.wake_pend = 1'b0;
            ctl_d.irq       = 1'b0;
        end else begin
            ctl_d.vprev = volt_any;
            ctl_d.irq   = 1'b0;
            if (ctl_q.wake_pend && wake_done_i) begin
                ctl_d.wake_pend = 1'b0;
                ctl_d.irq       = 1'b1;
            end else if (volt_any && !ctl_q.vprev) begin
                ctl_d.status = 4'(CS_ALOW) + {{(4 - VW){1'b0}}, volt_idx};
                if (is_sleep) ctl_d.wake_pend = 1'b1;
                else          ctl_d.irq       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) ctl_q <= CTL_RST;
        else       ctl_q <= ctl_d;
    end

    // assertion side is asynchronous; release comes from the stretcher
    assign sys_rst_o  = por_i || prec_hit || slv_hit || !pin_rst_n_i
                        || wdt_expire_i || sw_rst_req_i || hold_busy;
    assign wake_req_o = ctl_q.wake_pend;
    assign lv_irq_o   = ctl_q.irq;
    assign status_o   = ctl_q.status;
endmodule

module rsa_checks (
    input logic       clk_i,
    input logic       por_i,
    input logic       wdt_expire_i,
    input logic       wake_done_i,
    input logic       sys_rst_o,
    input logic       wake_req_o,
    input logic       lv_irq_o,
    input logic [3:0] status_o
);
    assert_wdt_rst_R1: assert property (@(posedge clk_i) disable iff (por_i)
        wdt_expire_i |-> sys_rst_o);

    assert_hold_after_wdt_R2: assert property (@(posedge clk_i) disable iff (por_i)
        $past(wdt_expire_i) |-> sys_rst_o);

    assert_status_code_R3: assert property (@(posedge clk_i) disable iff (por_i)
        (status_o >= 4'd1) && (status_o <= 4'd9));

    assert_irq_pulse_R10: assert property (@(posedge clk_i) disable iff (por_i)
        lv_irq_o |=> !lv_irq_o);

    assert_wake_held_R11: assert property (@(posedge clk_i) disable iff (por_i)
        (wake_req_o && !wake_done_i && !sys_rst_o) |=> wake_req_o);

    assert_wake_irq_excl_R11: assert property (@(posedge clk_i) disable iff (por_i)
        $onehot0({wake_req_o, lv_irq_o}));
endmodule

bind rst_source_arbiter rsa_checks u_rsa_checks (
    .clk_i        (clk_i),
    .por_i        (por_i),
    .wdt_expire_i (wdt_expire_i),
    .wake_done_i  (wake_done_i),
    .sys_rst_o    (sys_rst_o),
    .wake_req_o   (wake_req_o),
    .lv_irq_o     (lv_irq_o),
    .status_o     (status_o)
);

// File: tb/sim_rst_source_arbiter.sv
`timescale 1ns/1ps
module sim_rst_source_arbiter;
    localparam int HOLD = 13;
    localparam real TCK = 8.0;

    logic clk = 1'b0;
    logic por, pdig, pana, aen, slv, pin_n, wdt, sw, alow, dlow, ahigh, buzz, wdone;
    logic [1:0] pmode;
    logic sys_rst, wake_req, lv_irq;
    logic [3:0] status;

    int checks = 0;
    int fails  = 0;

    always #(TCK / 2) clk = ~clk;

    rst_source_arbiter #(.HOLD_CYCLES(HOLD)) u0 (
        .clk_i(clk), .por_i(por), .prec_dig_lv_i(pdig), .prec_ana_lv_i(pana),
        .ana_reg_en_i(aen), .sleep_lv_i(slv), .pin_rst_n_i(pin_n),
        .wdt_expire_i(wdt), .sw_rst_req_i(sw), .ana_low_i(alow), .dig_low_i(dlow),
        .ana_high_i(ahigh), .pmode_i(pmode), .buzz_i(buzz), .wake_done_i(wdone),
        .sys_rst_o(sys_rst), .wake_req_o(wake_req), .lv_irq_o(lv_irq), .status_o(status)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic       bz, pd, pa, ae, sl, pn, wd, sr, al, dl, ah;
        logic       exp_rst;
        logic [3:0] exp_st;
    } vec_t;

    localparam int NV = 18;
    // mode bz pd pa ae sl pn wd sr al dl ah | rst status
    localparam vec_t VECS [NV] = '{
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd5}, // R1 watchdog
        '{2'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,4'd5}, // R7 analog, regulator off
        '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd2}, // R7 analog, regulator on
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,4'd6}, // R1 software
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd4}, // R1 pin
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,4'd4}, // R6 active ignores
        '{2'd2,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd3}, // R6 hibernate
        '{2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,4'd3}, // R8 sleep, no buzz
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd5}, // R1 watchdog in sleep
        '{2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd2}, // R8 sleep buzz
        '{2'd2,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,4'd2}, // R8 hibernate
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,4'd4}, // R5 pin beats wdt/sw
        '{2'd2,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd3}, // R5 sleep LV beats wdt
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 1'b0,4'd7}, // R5 R10 analog low wins
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,4'd9}, // R10 analog high
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,4'd9}, // R11 sleep, no buzz
        '{2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,4'd9}, // R11 hibernate
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,4'd8}  // R3 digital low
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        pdig = 0; pana = 0; aen = 0; slv = 0; pin_n = 1; wdt = 0; sw = 0;
        alow = 0; dlow = 0; ahigh = 0; pmode = 2'd0; buzz = 0; wdone = 0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(TCK * 100000);
        fails++;
        $display("FAIL watchdog: actual hung, expected completion");
        finish_run();
    end

    initial begin
        int irqs;
        idle();
        por = 1;
        alow = 1;
        step(3);
        // R4 reset state
        chk("R4", "status in power-on", int'(status), 1);
        chk("R1", "sys_rst in power-on", int'(sys_rst), 1);
        chk("R9", "irq in power-on", int'(lv_irq), 0);
        chk("R11", "wake in power-on", int'(wake_req), 0);

        // R2 power-on stretch, R9 monitors held off during the hold
        por = 0;
        irqs = 0;
        for (int i = 0; i < HOLD - 1; i++) begin
            step(1);
            irqs += int'(lv_irq);
        end
        chk("R2", "sys_rst one edge before release", int'(sys_rst), 1);
        chk("R9", "irq during power-on hold", irqs, 0);
        step(1);
        chk("R2", "sys_rst at release", int'(sys_rst), 0);
        irqs = 0;
        for (int i = 0; i < 5; i++) begin
            step(1);
            irqs += int'(lv_irq);
        end
        chk("R9", "irq pulses after hold", irqs, 1);
        chk("R3", "status after analog low", int'(status), 7);
        idle();
        step(3);

        // vector walk
        for (int v = 0; v < NV; v++) begin
            pmode = VECS[v].mode; buzz = VECS[v].bz; pdig = VECS[v].pd;
            pana = VECS[v].pa; aen = VECS[v].ae; slv = VECS[v].sl;
            pin_n = VECS[v].pn; wdt = VECS[v].wd; sw = VECS[v].sr;
            alow = VECS[v].al; dlow = VECS[v].dl; ahigh = VECS[v].ah;
            step(3);
            checks++;
            if (sys_rst !== VECS[v].exp_rst) begin
                fails++;
                $display("FAIL R1 vector %0d sys_rst: actual %0d expected %0d",
                         v, sys_rst, VECS[v].exp_rst);
            end
            checks++;
            if (status !== VECS[v].exp_st) begin
                fails++;
                $display("FAIL R3 vector %0d status: actual %0d expected %0d",
                         v, status, VECS[v].exp_st);
            end
            idle();
            step(HOLD + 5);
        end

        // R2 exact hold after a one-cycle watchdog
        wdt = 1;
        step(1);
        wdt = 0;
        chk("R2", "sys_rst right after wdt edge", int'(sys_rst), 1);
        step(HOLD - 1);
        chk("R2", "sys_rst last hold cycle", int'(sys_rst), 1);
        step(1);
        chk("R2", "sys_rst after hold", int'(sys_rst), 0);
        step(3);

        // R1 asynchronous pin assertion, R12 synchronizer latency
        pin_n = 0;
        #1;
        chk("R1", "pin reset before any edge", int'(sys_rst), 1);
        step(2);
        chk("R12", "status two edges after pin", int'(status), 5);
        step(1);
        chk("R12", "status three edges after pin", int'(status), 4);
        pin_n = 1;
        step(HOLD + 5);

        // R10 active interrupt pulse
        dlow = 1;
        step(1);
        chk("R10", "irq after rise", int'(lv_irq), 1);
        chk("R10", "status after rise", int'(status), 8);
        step(1);
        chk("R10", "irq second cycle", int'(lv_irq), 0);
        dlow = 0;
        step(2);

        // R11 sleep buzz wakeup sequence
        pmode = 2'd1; buzz = 1; ahigh = 1;
        step(1);
        chk("R11", "wake request set", int'(wake_req), 1);
        chk("R11", "no irq before wakeup", int'(lv_irq), 0);
        chk("R3", "status on buzz event", int'(status), 9);
        buzz = 0; ahigh = 0;
        step(2);
        chk("R11", "wake request held", int'(wake_req), 1);
        wdone = 1;
        step(1);
        wdone = 0;
        chk("R11", "wake request cleared", int'(wake_req), 0);
        chk("R11", "irq after wakeup", int'(lv_irq), 1);
        step(1);
        chk("R11", "irq one cycle only", int'(lv_irq), 0);
        idle();
        step(2);

        // R4 power-on overwrites the recorded cause at once
        por = 1;
        #1;
        chk("R4", "status on power-on", int'(status), 1);
        step(2);
        por = 0;
        step(HOLD + 3);
        chk("R4", "status after power-on release", int'(status), 1);

        finish_run();
    end
endmodule